// File: doc/BRIEF.md
# CAN Message Time Stamp Unit

This block keeps a free-running counter that advances once per CAN bit-time tick. At the start of every frame's identifier field it takes a snapshot of that counter. The snapshot is held until the frame's outcome is known. It is then handed to the mailbox storage through a single-cycle write port that carries a mailbox index and a value. The mailbox memory and the frame decoder sit outside the block.

A received frame commits its snapshot in the cycle the frame is stored into its mailbox. A transmitted frame commits its snapshot only once transmission has completed successfully. A failed transmission drops the snapshot. A synchronisation control lets a store into one designated mailbox (mailbox 0 by default) clear the counter. Nodes can use this to align their time bases on a reference message.

Top module: `can_tstamp`

## Requirements
- R1: The counter is CNT_W bits wide (default 16) and reads 0 after reset; `ts_wr` is 0 after reset.
- R2: A cycle with `bit_tick` high raises `cnt_val` by one on the next cycle; without a tick (and no sync clear) `cnt_val` holds its value.
- R3: The counter wraps from its all-ones value to 0 on a tick, with no flag or other output effect.
- R4: `id_start` stores the value `cnt_val` shows in that same cycle as the frame's snapshot. A tick in the same cycle does not alter the stored value.
- R5: `rx_store` with a held snapshot produces, on the next cycle, `ts_wr`=1, `ts_idx`=`rx_idx` and `ts_val`=snapshot. `ts_wr` lasts exactly one cycle.
- R6: `tx_done` with a held snapshot produces, on the next cycle, `ts_wr`=1, `ts_idx`=`tx_idx` and `ts_val`=snapshot.
- R7: `tx_fail` discards the held snapshot without a write. Any commit strobe seen while no snapshot is held (none since reset, or already consumed) produces no write.
- R8: When `sync_en`=1 and `rx_store` is high with `rx_idx` equal to SYNC_IDX, `cnt_val` reads 0 on the next cycle. This holds even if `bit_tick` is high in that cycle. With `sync_en`=0, or any other index, the counter is unaffected.
- R9: A sync clear still writes the snapshot taken before the clear as that frame's time stamp.
- R10: If `rx_store` and `tx_done` arrive together, the receive commit wins. The snapshot is consumed, so the transmit side gets no write.
- R11: If `id_start` coincides with a commit strobe, the commit uses the previous snapshot. The new snapshot is kept for the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per CAN bit time |
| id_start | input | 1 | Start of identifier field seen on the bus |
| rx_store | input | 1 | Received frame is being stored into a mailbox |
| rx_idx | input | MB_W | Mailbox receiving the frame |
| tx_done | input | 1 | Transmission finished successfully |
| tx_fail | input | 1 | Transmission failed or aborted |
| tx_idx | input | MB_W | Mailbox whose frame was sent |
| sync_en | input | 1 | Enables counter clear on store into SYNC_IDX |
| ts_wr | output | 1 | Time-stamp write strobe |
| ts_idx | output | MB_W | Mailbox index of the write |
| ts_val | output | CNT_W | Time-stamp value written |
| cnt_val | output | CNT_W | Live counter value |

## Verification
The bench builds the block with CNT_W=8, MB_W=3 and SYNC_IDX=0. The narrow counter puts the wrap from 255 to 0 within a few hundred ticks, so R3 is checked directly instead of after 65536 bit times. The three-bit index still lets the bench tell the sync mailbox apart from others and spot crossed receive and transmit indices. Coincident events (sync clear with tick, snapshot with commit, receive with transmit completion) are each driven in one cycle.

// File: rtl/can_tstamp_pkg.sv
package can_tstamp_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RX   = 2'd1,
    SRC_TX   = 2'd2
  } commit_src_e;
endpackage

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = tick | clr;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R8
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             consume,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap,
  output logic             snap_vld
);
  logic [CNT_W-1:0] snap_q, snap_d;
  logic             vld_q, vld_d;

  always_comb begin
    snap_d = cnt;
    if (take)         vld_d = 1'b1;
    else if (consume) vld_d = 1'b0;
    else              vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (take) snap_q <= snap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign snap     = snap_q;
  assign snap_vld = vld_q;

  // R4
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (snap_vld && snap == $past(cnt)));
  // R7
  snap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !take) |=> !snap_vld);
endmodule

// File: rtl/tstamp_commit.sv
module tstamp_commit
  import can_tstamp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int MB_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_store,
  input  logic [MB_W-1:0]  rx_idx,
  input  logic             tx_done,
  input  logic             tx_fail,
  input  logic [MB_W-1:0]  tx_idx,
  input  logic [CNT_W-1:0] snap,
  input  logic             snap_vld,
  output logic             consume,
  output logic             wr,
  output logic [MB_W-1:0]  wr_idx,
  output logic [CNT_W-1:0] wr_val
);
  commit_src_e      src;
  logic             wr_q, wr_d;
  logic [MB_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0] val_q, val_d;

  always_comb begin
    src = SRC_NONE;
    if (snap_vld) begin
      if (rx_store)     src = SRC_RX;
      else if (tx_done) src = SRC_TX;
    end
    consume = rx_store | tx_done | tx_fail;
    wr_d    = (src != SRC_NONE);
    idx_d   = (src == SRC_RX) ? rx_idx : tx_idx;
    val_d   = snap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      val_q <= '0;
    end else if (wr_d) begin
      idx_q <= idx_d;
      val_q <= val_d;
    end
  end

  assign wr     = wr_q;
  assign wr_idx = idx_q;
  assign wr_val = val_q;

  // R5
  rx_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_vld && rx_store) |=> (wr && wr_idx == $past(rx_idx) && wr_val == $past(snap)));
  // R6
  tx_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_vld && tx_done && !rx_store) |=> (wr && wr_idx == $past(tx_idx)));
  // R7
  no_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_vld |=> !wr);
  // R7
  fail_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fail && !rx_store && !tx_done) |=> !wr);
endmodule

// File: rtl/can_tstamp.sv
module can_tstamp #(
  parameter int          CNT_W    = 16,
  parameter int          MB_W     = 4,
  parameter int unsigned SYNC_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             id_start,
  input  logic             rx_store,
  input  logic [MB_W-1:0]  rx_idx,
  input  logic             tx_done,
  input  logic             tx_fail,
  input  logic [MB_W-1:0]  tx_idx,
  input  logic             sync_en,
  output logic             ts_wr,
  output logic [MB_W-1:0]  ts_idx,
  output logic [CNT_W-1:0] ts_val,
  output logic [CNT_W-1:0] cnt_val
);
  localparam logic [MB_W-1:0] SYNC_SEL = MB_W'(SYNC_IDX);

  logic             sync_clr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] snap;
  logic             snap_vld;
  logic             consume;

  always_comb begin
    sync_clr = sync_en & rx_store & (rx_idx == SYNC_SEL);
  end

  tstamp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (bit_tick),
    .clr   (sync_clr),
    .cnt   (cnt)
  );

  tstamp_capture #(.CNT_W(CNT_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (id_start),
    .consume  (consume),
    .cnt      (cnt),
    .snap     (snap),
    .snap_vld (snap_vld)
  );

  tstamp_commit #(.CNT_W(CNT_W), .MB_W(MB_W)) u_cmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_store (rx_store),
    .rx_idx   (rx_idx),
    .tx_done  (tx_done),
    .tx_fail  (tx_fail),
    .tx_idx   (tx_idx),
    .snap     (snap),
    .snap_vld (snap_vld),
    .consume  (consume),
    .wr       (ts_wr),
    .wr_idx   (ts_idx),
    .wr_val   (ts_val)
  );

  assign cnt_val = cnt;

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !sync_clr && cnt_val == '1) |=> (cnt_val == '0));
  // R10
  rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_store && tx_done && snap_vld) |=> (ts_wr && ts_idx == $past(rx_idx)));
  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_wr && !$past(rx_store) && !$past(tx_done)) |-> 1'b0);
endmodule

// File: tb/can_tstamp_tb.sv
module can_tstamp_tb;
  localparam int CNT_W = 8;
  localparam int MB_W  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_tick = 1'b0, id_start = 1'b0, rx_store = 1'b0;
  logic             tx_done = 1'b0, tx_fail = 1'b0, sync_en = 1'b0;
  logic [MB_W-1:0]  rx_idx = '0, tx_idx = '0;
  logic             ts_wr;
  logic [MB_W-1:0]  ts_idx;
  logic [CNT_W-1:0] ts_val, cnt_val;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_tstamp #(.CNT_W(CNT_W), .MB_W(MB_W), .SYNC_IDX(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .id_start(id_start),
    .rx_store(rx_store), .rx_idx(rx_idx), .tx_done(tx_done), .tx_fail(tx_fail),
    .tx_idx(tx_idx), .sync_en(sync_en), .ts_wr(ts_wr), .ts_idx(ts_idx),
    .ts_val(ts_val), .cnt_val(cnt_val)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    bit_tick = 0; id_start = 0; rx_store = 0; tx_done = 0; tx_fail = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    idle(); sync_en = 0;
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; cyc(); end
    bit_tick = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt after reset", cnt_val, 0);
    chk("R1 ts_wr after reset", ts_wr, 0);
  endtask

  task automatic t_count_wrap();
    do_reset();
    ticks(7);
    chk("R2 count", cnt_val, 7);
    cyc(); cyc();
    chk("R2 hold", cnt_val, 7);
    ticks(248);
    chk("R3 max", cnt_val, 255);
    ticks(1);
    chk("R3 wrap", cnt_val, 0);
    chk("R3 no write", ts_wr, 0);
  endtask

  task automatic t_rx();
    do_reset();
    ticks(5);
    id_start = 1; bit_tick = 1; cyc(); idle();
    ticks(3);
    rx_store = 1; rx_idx = 3; cyc(); idle();
    chk("R5 rx wr", ts_wr, 1);
    chk("R5 rx idx", ts_idx, 3);
    chk("R4 rx val", ts_val, 5);
    cyc();
    chk("R5 pulse", ts_wr, 0);
  endtask

  task automatic t_tx();
    do_reset();
    ticks(2);
    id_start = 1; cyc(); idle();
    ticks(4);
    tx_done = 1; tx_idx = 6; cyc(); idle();
    chk("R6 tx wr", ts_wr, 1);
    chk("R6 tx idx", ts_idx, 6);
    chk("R6 tx val", ts_val, 2);
    id_start = 1; cyc(); idle();
    tx_fail = 1; cyc(); idle();
    chk("R7 fail no wr", ts_wr, 0);
    tx_done = 1; cyc(); idle();
    chk("R7 dropped snap", ts_wr, 0);
    rx_store = 1; rx_idx = 2; cyc(); idle();
    chk("R7 no snap rx", ts_wr, 0);
  endtask

  task automatic t_sync();
    do_reset();
    ticks(10);
    id_start = 1; cyc(); idle();
    sync_en = 0; rx_store = 1; rx_idx = 0; cyc(); idle();
    chk("R8 sync off", cnt_val, 10);
    id_start = 1; cyc(); idle();
    sync_en = 1; rx_store = 1; rx_idx = 1; cyc(); idle();
    chk("R8 other idx", cnt_val, 10);
    id_start = 1; cyc(); idle();
    rx_store = 1; rx_idx = 0; bit_tick = 1; cyc(); idle();
    chk("R8 clear wins", cnt_val, 0);
    chk("R9 wr", ts_wr, 1);
    chk("R9 pre-clear val", ts_val, 10);
    sync_en = 0;
  endtask

  task automatic t_collide();
    do_reset();
    ticks(4);
    id_start = 1; cyc(); idle();
    rx_store = 1; rx_idx = 2; tx_done = 1; tx_idx = 5; cyc(); idle();
    chk("R10 rx wins", ts_idx, 2);
    tx_done = 1; tx_idx = 5; cyc(); idle();
    chk("R10 tx dropped", ts_wr, 0);
    ticks(3);
    id_start = 1; cyc(); idle();
    ticks(4);
    rx_store = 1; rx_idx = 1; id_start = 1; cyc(); idle();
    chk("R11 old snap", ts_val, 7);
    ticks(2);
    tx_done = 1; tx_idx = 4; cyc(); idle();
    chk("R11 new snap wr", ts_wr, 1);
    chk("R11 new snap val", ts_val, 11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_count_wrap();
    t_rx();
    t_tx();
    t_sync();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule